// File: doc/BRIEF.md
# Dual Stack RAM with Limit Check

This block keeps two stacks in one shared 64-word by 16-bit RAM. One is a subroutine stack with a dedicated 6-bit pointer. It grows upward: a push increments the pointer and then writes, and a pop reads and then decrements. The other is a register stack with two 6-bit pointers, one local and one global. The `rs_sel` input chooses which of the two is active. The register stack grows downward: a push decrements the active pointer and then writes, and a pop reads and then increments. Because the stacks grow toward each other, they can share the RAM.

Each cycle, a small selector decides one action for each stack.

- The subroutine selector picks one of **SSA_IDLE**, **SSA_PUSH**, **SSA_POP** or **SSA_LOAD**.
- The register selector picks one of **RSA_IDLE**, **RSA_PUSH**, **RSA_POP**, **RSA_ADD** or **RSA_LOAD** for the active pointer.

The rules that choose between these actions are:

- A pointer load takes precedence over any other action on the same stack.
- A push and a pop requested together on one stack fall back to idle.
- A register push demotes to RSA_IDLE when a subroutine push takes effect in the same cycle, since the RAM has one write port.
- An add applies only when neither a register push nor a register pop is requested.

Read ports are combinational and use the pointers as they stand before the clock edge. The subroutine top, the register top, four register operands at the active pointer plus a 2-bit offset, and any location by direct index are always readable. A 4-bit limit register, padded on the right by the push direction, detects a coming overflow. Popping location zero flags an underflow. Both flags are one-cycle pulses, registered on the edge after the offending operation.

Top module: `dstack_ram`

## Requirements
- R1: After reset `ssp`, `lsp` and `gsp` are all 0, the limit register is 0, and `ovf_req` and `unf_req` are low.
- R2: A subroutine push (ss_push alone) writes `ss_wdata` at ssp+1, and `ssp` becomes ssp+1. A subroutine pop (ss_pop alone) presents mem[ssp] on `ss_rdata` in that cycle, and `ssp` becomes ssp-1.
- R3: The active register pointer is lsp when `rs_sel`=0 and gsp when `rs_sel`=1. A register push (rs_push alone) writes `rs_wdata` at active-1, and the active pointer becomes active-1. A register pop presents mem[active] on `rs_rdata`, and the pointer becomes active+1. The inactive pointer is unchanged.
- R4: A push and a pop requested together on the same stack are ignored: no pointer change, no RAM write and no flag.
- R5: A register push in a cycle where a subroutine push takes effect is ignored. The subroutine push completes.
- R6: When `ld_en` is high, `ld_sel` picks the pointer loaded with `ld_val` (0 = subroutine, 1 = local, 2 = global, 3 = none). Push, pop and add requests aimed at the pointer being loaded are ignored in that cycle.
- R7: With `rs_add_en` high and neither rs_push nor rs_pop requested, the active pointer becomes active + `rs_add_val` (unsigned, modulo 64).
- R8: `reg_rdata` always shows mem[(active + reg_off) mod 64].
- R9: `idx_rdata` always shows mem[idx_addr].
- R10: `lim_wr` loads `lim_val` into the limit register. `ovf_req` is high for the one cycle after a subroutine push whose new pointer equals {limit,2'b00}, or a register push whose new pointer equals {limit,2'b11}. Otherwise it is low.
- R11: `unf_req` is high for the one cycle after a pop that takes effect on either stack with a pre-update pointer of 0. Otherwise it is low.
- R12: All pointers wrap modulo 64 on increment, decrement and add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_push | input | 1 | Subroutine stack push request |
| ss_pop | input | 1 | Subroutine stack pop request |
| ss_wdata | input | 16 | Data for a subroutine push |
| rs_push | input | 1 | Register stack push request |
| rs_pop | input | 1 | Register stack pop request |
| rs_wdata | input | 16 | Data for a register push |
| rs_sel | input | 1 | Active register pointer: 0 local, 1 global |
| rs_add_en | input | 1 | Add rs_add_val to the active register pointer |
| rs_add_val | input | 3 | Unsigned amount for the add |
| ld_en | input | 1 | Pointer load enable |
| ld_sel | input | 2 | Load target: 0 subroutine, 1 local, 2 global |
| ld_val | input | 6 | Value loaded into the selected pointer |
| lim_wr | input | 1 | Write enable for the limit register |
| lim_val | input | 4 | New limit value |
| reg_off | input | 2 | Offset for the register operand read |
| idx_addr | input | 6 | Address for the direct indexed read |
| ss_rdata | output | 16 | mem[ssp] |
| rs_rdata | output | 16 | mem[active register pointer] |
| reg_rdata | output | 16 | mem[active + reg_off] |
| idx_rdata | output | 16 | mem[idx_addr] |
| ssp | output | 6 | Subroutine stack pointer |
| lsp | output | 6 | Local register pointer |
| gsp | output | 6 | Global register pointer |
| ovf_req | output | 1 | Stack overflow pulse |
| unf_req | output | 1 | Stack underflow pulse |

## Verification
The bench builds the block with its defaults: 16-bit data, 6-bit pointers, a 4-bit limit and a 3-bit add amount. With the RAM only 64 words deep, every pointer can be driven across the 0/63 boundary in either direction within a few cycles. Both limit paddings can be hit as well as narrowly missed, for example a register push landing on {limit,2'b00}. A randomized phase mixes concurrent pushes, pops, adds and loads on both stacks, so every priority rule between the selector actions meets its conflicting neighbours many times.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

    typedef enum logic [1:0] {
        SSA_IDLE,
        SSA_PUSH,
        SSA_POP,
        SSA_LOAD
    } ss_act_e;

    typedef enum logic [2:0] {
        RSA_IDLE,
        RSA_PUSH,
        RSA_POP,
        RSA_ADD,
        RSA_LOAD
    } rs_act_e;

    localparam logic [1:0] PSEL_SS  = 2'd0;
    localparam logic [1:0] PSEL_LOC = 2'd1;
    localparam logic [1:0] PSEL_GLB = 2'd2;

endpackage

// File: rtl/dstk_ctrl.sv
module dstk_ctrl
    import dstk_pkg::*;
(
    input  logic       ss_push,
    input  logic       ss_pop,
    input  logic       rs_push,
    input  logic       rs_pop,
    input  logic       rs_add_en,
    input  logic       rs_sel,
    input  logic       ld_en,
    input  logic [1:0] ld_sel,
    output ss_act_e    ss_act,
    output rs_act_e    rs_act
);

    logic ld_ss;
    logic ld_act;

    assign ld_ss  = ld_en && (ld_sel == PSEL_SS);
    assign ld_act = ld_en && (ld_sel == (rs_sel ? PSEL_GLB : PSEL_LOC));

    // subroutine selector: load > single push/pop > idle
    always_comb begin
        unique casez ({ld_ss, ss_push, ss_pop})
            3'b1??:  ss_act = SSA_LOAD;
            3'b010:  ss_act = SSA_PUSH;
            3'b001:  ss_act = SSA_POP;
            default: ss_act = SSA_IDLE;
        endcase
    end

    // register selector: load > single push/pop > add > idle
    always_comb begin
        unique casez ({ld_act, rs_push, rs_pop, rs_add_en})
            4'b1???: rs_act = RSA_LOAD;
            4'b010?: rs_act = (ss_act == SSA_PUSH) ? RSA_IDLE : RSA_PUSH;
            4'b001?: rs_act = RSA_POP;
            4'b0001: rs_act = RSA_ADD;
            default: rs_act = RSA_IDLE;
        endcase
    end

endmodule

// File: rtl/dstk_ptrs.sv
module dstk_ptrs
    import dstk_pkg::*;
#(
    parameter int PTR_W = 6,
    parameter int ADD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ss_act_e          ss_act,
    input  rs_act_e          rs_act,
    input  logic             rs_sel,
    input  logic             ld_en,
    input  logic [1:0]       ld_sel,
    input  logic [PTR_W-1:0] ld_val,
    input  logic [ADD_W-1:0] add_val,
    output logic [PTR_W-1:0] ssp,
    output logic [PTR_W-1:0] lsp,
    output logic [PTR_W-1:0] gsp,
    output logic [PTR_W-1:0] act_ptr
);

    localparam int ZPAD = PTR_W - ADD_W;

    logic [PTR_W-1:0] ssp_q, lsp_q, gsp_q;
    logic [PTR_W-1:0] ssp_n, lsp_n, gsp_n, act_n;

    assign act_ptr = rs_sel ? gsp_q : lsp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssp_q <= '0;
            lsp_q <= '0;
            gsp_q <= '0;
        end else begin
            ssp_q <= ssp_n;
            lsp_q <= lsp_n;
            gsp_q <= gsp_n;
        end
    end

    always_comb begin
        ssp_n = ssp_q;
        unique case (ss_act)
            SSA_IDLE: ssp_n = ssp_q;
            SSA_PUSH: ssp_n = ssp_q + 1'b1;
            SSA_POP:  ssp_n = ssp_q - 1'b1;
            SSA_LOAD: ssp_n = ld_val;
            default:  ssp_n = ssp_q;
        endcase

        act_n = act_ptr;
        unique case (rs_act)
            RSA_IDLE: act_n = act_ptr;
            RSA_PUSH: act_n = act_ptr - 1'b1;
            RSA_POP:  act_n = act_ptr + 1'b1;
            RSA_ADD:  act_n = act_ptr + {{ZPAD{1'b0}}, add_val};
            RSA_LOAD: act_n = ld_val;
            default:  act_n = act_ptr;
        endcase

        if (rs_sel) begin
            gsp_n = act_n;
            lsp_n = (ld_en && ld_sel == PSEL_LOC) ? ld_val : lsp_q;
        end else begin
            lsp_n = act_n;
            gsp_n = (ld_en && ld_sel == PSEL_GLB) ? ld_val : gsp_q;
        end
    end

    assign ssp = ssp_q;
    assign lsp = lsp_q;
    assign gsp = gsp_q;

endmodule

// File: rtl/dstk_mem.sv
module dstk_mem #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 6,
    parameter int RD_N   = 4
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [PTR_W-1:0]              waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [RD_N-1:0][PTR_W-1:0]    raddr,
    output logic [RD_N-1:0][DATA_W-1:0]   rdata
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    for (genvar g = 0; g < RD_N; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end

endmodule

// File: rtl/dstk_guard.sv
module dstk_guard #(
    parameter int PTR_W = 6,
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic [LIM_W-1:0] lim_val,
    input  logic             ss_push_go,
    input  logic             rs_push_go,
    input  logic             ss_pop_go,
    input  logic             rs_pop_go,
    input  logic [PTR_W-1:0] ssp,
    input  logic [PTR_W-1:0] act_ptr,
    output logic             ovf_req,
    output logic             unf_req
);

    localparam int PAD = PTR_W - LIM_W;

    logic [LIM_W-1:0] lim_q;
    logic [PTR_W-1:0] ss_next, rs_next;
    logic             ovf_hit, unf_hit;

    assign ss_next = ssp + 1'b1;
    assign rs_next = act_ptr - 1'b1;

    assign ovf_hit = (ss_push_go && ss_next == {lim_q, {PAD{1'b0}}})
                  || (rs_push_go && rs_next == {lim_q, {PAD{1'b1}}});
    assign unf_hit = (ss_pop_go && ssp == '0) || (rs_pop_go && act_ptr == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q   <= '0;
            ovf_req <= 1'b0;
            unf_req <= 1'b0;
        end else begin
            if (lim_wr) lim_q <= lim_val;
            ovf_req <= ovf_hit;
            unf_req <= unf_hit;
        end
    end

endmodule

// File: rtl/dstack_ram.sv
module dstack_ram
    import dstk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 6,
    parameter int LIM_W  = 4,
    parameter int ADD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_push,
    input  logic              ss_pop,
    input  logic [DATA_W-1:0] ss_wdata,
    input  logic              rs_push,
    input  logic              rs_pop,
    input  logic [DATA_W-1:0] rs_wdata,
    input  logic              rs_sel,
    input  logic              rs_add_en,
    input  logic [ADD_W-1:0]  rs_add_val,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              lim_wr,
    input  logic [LIM_W-1:0]  lim_val,
    input  logic [1:0]        reg_off,
    input  logic [PTR_W-1:0]  idx_addr,
    output logic [DATA_W-1:0] ss_rdata,
    output logic [DATA_W-1:0] rs_rdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] idx_rdata,
    output logic [PTR_W-1:0]  ssp,
    output logic [PTR_W-1:0]  lsp,
    output logic [PTR_W-1:0]  gsp,
    output logic              ovf_req,
    output logic              unf_req
);

    localparam int RD_N = 4;

    ss_act_e ss_act;
    rs_act_e rs_act;

    logic [PTR_W-1:0]             act_ptr;
    logic                         we;
    logic [PTR_W-1:0]             waddr;
    logic [DATA_W-1:0]            wdata;
    logic [RD_N-1:0][PTR_W-1:0]   raddr;
    logic [RD_N-1:0][DATA_W-1:0]  rdata;

    dstk_ctrl u_ctrl (
        .ss_push   (ss_push),
        .ss_pop    (ss_pop),
        .rs_push   (rs_push),
        .rs_pop    (rs_pop),
        .rs_add_en (rs_add_en),
        .rs_sel    (rs_sel),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ss_act    (ss_act),
        .rs_act    (rs_act)
    );

    dstk_ptrs #(.PTR_W(PTR_W), .ADD_W(ADD_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ss_act  (ss_act),
        .rs_act  (rs_act),
        .rs_sel  (rs_sel),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_val  (ld_val),
        .add_val (rs_add_val),
        .ssp     (ssp),
        .lsp     (lsp),
        .gsp     (gsp),
        .act_ptr (act_ptr)
    );

    assign we    = (ss_act == SSA_PUSH) || (rs_act == RSA_PUSH);
    assign waddr = (ss_act == SSA_PUSH) ? ssp + 1'b1 : act_ptr - 1'b1;
    assign wdata = (ss_act == SSA_PUSH) ? ss_wdata : rs_wdata;

    assign raddr[0] = ssp;
    assign raddr[1] = act_ptr;
    assign raddr[2] = act_ptr + {{(PTR_W-2){1'b0}}, reg_off};
    assign raddr[3] = idx_addr;

    dstk_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W), .RD_N(RD_N)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign ss_rdata  = rdata[0];
    assign rs_rdata  = rdata[1];
    assign reg_rdata = rdata[2];
    assign idx_rdata = rdata[3];

    dstk_guard #(.PTR_W(PTR_W), .LIM_W(LIM_W)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .lim_wr     (lim_wr),
        .lim_val    (lim_val),
        .ss_push_go (ss_act == SSA_PUSH),
        .rs_push_go (rs_act == RSA_PUSH),
        .ss_pop_go  (ss_act == SSA_POP),
        .rs_pop_go  (rs_act == RSA_POP),
        .ssp        (ssp),
        .act_ptr    (act_ptr),
        .ovf_req    (ovf_req),
        .unf_req    (unf_req)
    );

endmodule

// File: rtl/dstack_ram_chk.sv
module dstack_ram_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ss_push,
    input logic             ss_pop,
    input logic             rs_push,
    input logic             rs_pop,
    input logic             rs_sel,
    input logic             ld_en,
    input logic [1:0]       ld_sel,
    input logic [PTR_W-1:0] ld_val,
    input logic [PTR_W-1:0] ssp,
    input logic [PTR_W-1:0] gsp,
    input logic             ovf_req,
    input logic             unf_req
);

    AST_SS_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_push && !ss_pop && !(ld_en && ld_sel == 2'd0)) |=> ssp == PTR_W'($past(ssp) + 1'b1)); // R2

    AST_GLOBAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_sel && !(ld_en && ld_sel == 2'd2)) |=> $stable(gsp)); // R3

    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_push && ss_pop && !(ld_en && ld_sel == 2'd0)) |=> $stable(ssp)); // R4

    AST_SS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_sel == 2'd0) |=> ssp == $past(ld_val)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_push && !rs_push) |=> !ovf_req); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_pop && !rs_pop) |=> !unf_req); // R11

endmodule

bind dstack_ram dstack_ram_chk #(.PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ss_push (ss_push),
    .ss_pop  (ss_pop),
    .rs_push (rs_push),
    .rs_pop  (rs_pop),
    .rs_sel  (rs_sel),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_val  (ld_val),
    .ssp     (ssp),
    .gsp     (gsp),
    .ovf_req (ovf_req),
    .unf_req (unf_req)
);

// File: tb/dstack_ram_bench.sv
`timescale 1ns/100ps
module dstack_ram_bench;

    localparam int DW = 16, AW = 6, LW = 4, XW = 3, DEPTH = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          ss_push, ss_pop, rs_push, rs_pop, rs_sel, rs_add_en;
    logic [DW-1:0] ss_wdata, rs_wdata;
    logic [XW-1:0] rs_add_val;
    logic          ld_en, lim_wr;
    logic [1:0]    ld_sel, reg_off;
    logic [AW-1:0] ld_val, idx_addr;
    logic [LW-1:0] lim_val;
    logic [DW-1:0] ss_rdata, rs_rdata, reg_rdata, idx_rdata;
    logic [AW-1:0] ssp, lsp, gsp;
    logic          ovf_req, unf_req;

    dstack_ram #(.DATA_W(DW), .PTR_W(AW), .LIM_W(LW), .ADD_W(XW)) u_dstack_ram (
        .clk(clk), .rst_n(rst_n),
        .ss_push(ss_push), .ss_pop(ss_pop), .ss_wdata(ss_wdata),
        .rs_push(rs_push), .rs_pop(rs_pop), .rs_wdata(rs_wdata),
        .rs_sel(rs_sel), .rs_add_en(rs_add_en), .rs_add_val(rs_add_val),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .lim_wr(lim_wr), .lim_val(lim_val),
        .reg_off(reg_off), .idx_addr(idx_addr),
        .ss_rdata(ss_rdata), .rs_rdata(rs_rdata), .reg_rdata(reg_rdata), .idx_rdata(idx_rdata),
        .ssp(ssp), .lsp(lsp), .gsp(gsp), .ovf_req(ovf_req), .unf_req(unf_req)
    );

    int n_run = 0, n_fail = 0;
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_vld [DEPTH];
    int            m_ssp, m_lsp, m_gsp, m_lim;
    bit            m_ovf, m_unf;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        ss_push = 0; ss_pop = 0; rs_push = 0; rs_pop = 0; rs_add_en = 0;
        ld_en = 0; lim_wr = 0;
    endtask

    task automatic compare_all();
        int a;
        a = rs_sel ? m_gsp : m_lsp;
        chk("R2 ssp", ssp, m_ssp);
        chk("R3 lsp", lsp, m_lsp);
        chk("R3 gsp", gsp, m_gsp);
        if (m_vld[m_ssp]) chk("R2 ss_rdata", ss_rdata, m_mem[m_ssp]);
        if (m_vld[a]) chk("R3 rs_rdata", rs_rdata, m_mem[a]);
        if (m_vld[(a + reg_off) % DEPTH]) chk("R8 reg_rdata", reg_rdata, m_mem[(a + reg_off) % DEPTH]);
        if (m_vld[idx_addr]) chk("R9 idx_rdata", idx_rdata, m_mem[idx_addr]);
        chk("R10 ovf_req", ovf_req, m_ovf);
        chk("R11 unf_req", unf_req, m_unf);
    endtask

    task automatic model_edge();
        bit ld_s, ld_l, ld_g, ld_a, s_push, s_pop, r_push, r_pop, r_add, novf, nunf;
        int a, na, nssp;
        ld_s = ld_en && ld_sel == 0;
        ld_l = ld_en && ld_sel == 1;
        ld_g = ld_en && ld_sel == 2;
        ld_a = rs_sel ? ld_g : ld_l;
        a    = rs_sel ? m_gsp : m_lsp;
        s_push = !ld_s && ss_push && !ss_pop;
        s_pop  = !ld_s && ss_pop && !ss_push;
        r_push = !ld_a && rs_push && !rs_pop && !s_push;
        r_pop  = !ld_a && rs_pop && !rs_push;
        r_add  = !ld_a && !rs_push && !rs_pop && rs_add_en;
        novf = 0; nunf = 0; nssp = m_ssp; na = a;
        if (ld_s) nssp = ld_val;
        else if (s_push) begin
            nssp = (m_ssp + 1) % DEPTH;
            m_mem[nssp] = ss_wdata; m_vld[nssp] = 1;
            if (nssp == m_lim * 4) novf = 1;
        end else if (s_pop) begin
            if (m_ssp == 0) nunf = 1;
            nssp = (m_ssp + DEPTH - 1) % DEPTH;
        end
        if (ld_a) na = ld_val;
        else if (r_push) begin
            na = (a + DEPTH - 1) % DEPTH;
            m_mem[na] = rs_wdata; m_vld[na] = 1;
            if (na == m_lim * 4 + 3) novf = 1;
        end else if (r_pop) begin
            if (a == 0) nunf = 1;
            na = (a + 1) % DEPTH;
        end else if (r_add) na = (a + rs_add_val) % DEPTH;
        m_ssp = nssp;
        if (rs_sel) begin m_gsp = na; if (ld_l) m_lsp = ld_val; end
        else begin m_lsp = na; if (ld_g) m_gsp = ld_val; end
        if (lim_wr) m_lim = lim_val;
        m_ovf = novf; m_unf = nunf;
    endtask

    task automatic cycle();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; idle_in();
        ss_wdata = 0; rs_wdata = 0; rs_sel = 0; rs_add_val = 0; ld_sel = 0; ld_val = 0;
        lim_val = 0; reg_off = 0; idx_addr = 0;
        m_ssp = 0; m_lsp = 0; m_gsp = 0; m_lim = 0; m_ovf = 0; m_unf = 0;
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 ssp reset", ssp, 0); chk("R1 lsp reset", lsp, 0); chk("R1 gsp reset", gsp, 0);
        chk("R1 ovf reset", ovf_req, 0); chk("R1 unf reset", unf_req, 0);
        @(negedge clk);

        // R2 subroutine pushes then pop
        ss_push = 1; ss_wdata = 16'hA001; cycle();
        ss_wdata = 16'hA002; cycle();
        ss_wdata = 16'hA003; cycle();
        idle_in(); idx_addr = 2; #1;
        chk("R2 ssp after pushes", ssp, 3);
        chk("R9 indexed read", idx_rdata, 16'hA002);
        @(negedge clk);
        ss_pop = 1; #1 chk("R2 pop data", ss_rdata, 16'hA003);
        cycle(); idle_in();
        chk("R2 ssp after pop", ssp, 2);

        // R3 local register pushes with wrap
        rs_sel = 0; rs_push = 1; rs_wdata = 16'hB001; cycle();
        rs_wdata = 16'hB002; cycle(); idle_in();
        chk("R12 local pointer wrapped", lsp, 62);
        reg_off = 1; #1 chk("R8 operand offset 1", reg_rdata, 16'hB001);
        reg_off = 0; #1 chk("R8 operand offset 0", reg_rdata, 16'hB002);
        @(negedge clk);

        // R6 global load, R3 global push
        ld_en = 1; ld_sel = 2; ld_val = 40; cycle(); idle_in();
        chk("R6 global load", gsp, 40);
        rs_sel = 1; rs_push = 1; rs_wdata = 16'hC001; cycle(); idle_in();
        chk("R3 global push", gsp, 39);
        chk("R3 local untouched", lsp, 62);

        // R4 push and pop together
        ss_push = 1; ss_pop = 1; ss_wdata = 16'hDEAD; cycle(); idle_in();
        chk("R4 ssp held", ssp, 2);
        idx_addr = 3; #1 chk("R4 no write", idx_rdata, 16'hA003);
        @(negedge clk);
        rs_push = 1; rs_pop = 1; cycle(); idle_in();
        chk("R4 gsp held", gsp, 39);

        // R5 simultaneous pushes
        ss_push = 1; ss_wdata = 16'hE001; rs_push = 1; rs_wdata = 16'hE002; cycle(); idle_in();
        chk("R5 ssp moved", ssp, 3);
        chk("R5 gsp held", gsp, 39);
        idx_addr = 3; #1 chk("R5 subroutine write", idx_rdata, 16'hE001);
        @(negedge clk);

        // R7 add with wrap
        rs_sel = 0; rs_add_en = 1; rs_add_val = 2; cycle(); idle_in();
        chk("R7 add wraps local", lsp, 0);

        // R6 load beats push
        ld_en = 1; ld_sel = 0; ld_val = 10; ss_push = 1; ss_wdata = 16'hF00F; cycle(); idle_in();
        chk("R6 load wins", ssp, 10);

        // R10 subroutine overflow
        lim_wr = 1; lim_val = 1; ld_en = 1; ld_sel = 0; ld_val = 3; cycle(); idle_in();
        ss_push = 1; ss_wdata = 16'h1111; cycle(); idle_in();
        chk("R10 subroutine overflow", ovf_req, 1);
        cycle();
        chk("R10 pulse ends", ovf_req, 0);

        // R10 register overflow with padding 11, and near miss
        lim_wr = 1; lim_val = 15; cycle(); idle_in();
        rs_sel = 0; rs_push = 1; rs_wdata = 16'h2222; cycle(); idle_in();
        chk("R10 register overflow", ovf_req, 1);
        chk("R12 local wrap down", lsp, 63);
        ld_en = 1; ld_sel = 1; ld_val = 61; cycle(); idle_in();
        rs_push = 1; rs_wdata = 16'h3333; cycle(); idle_in();
        chk("R10 padding mismatch quiet", ovf_req, 0);

        // R11 underflow on both stacks
        ld_en = 1; ld_sel = 0; ld_val = 0; cycle(); idle_in();
        ss_pop = 1; cycle(); idle_in();
        chk("R11 subroutine underflow", unf_req, 1);
        chk("R12 ssp wrap", ssp, 63);
        cycle();
        chk("R11 pulse ends", unf_req, 0);
        rs_sel = 1; ld_en = 1; ld_sel = 2; ld_val = 0; cycle(); idle_in();
        rs_pop = 1; cycle(); idle_in();
        chk("R11 register underflow", unf_req, 1);
        chk("R3 global pop", gsp, 1);

        // mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            ss_push    = ($urandom % 3) == 0;
            ss_pop     = ($urandom % 3) == 0;
            rs_push    = ($urandom % 3) == 0;
            rs_pop     = ($urandom % 3) == 0;
            rs_add_en  = ($urandom % 4) == 0;
            rs_add_val = XW'($urandom);
            rs_sel     = 1'($urandom);
            ld_en      = ($urandom % 12) == 0;
            ld_sel     = 2'($urandom);
            ld_val     = AW'($urandom);
            lim_wr     = ($urandom % 20) == 0;
            lim_val    = LW'($urandom);
            ss_wdata   = DW'($urandom);
            rs_wdata   = DW'($urandom);
            reg_off    = 2'($urandom);
            idx_addr   = AW'($urandom);
            cycle();
        end
        idle_in();
        cycle();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule